// File: doc/BRIEF.md
# Control Endpoint SETUP Handler

This block sits between a USB packet engine and device firmware, and it manages the default control endpoint. The packet engine has already decoded the tokens and checked the data packets. It passes in pulses for a SETUP token, an OUT token and the end of a data packet, along with a stream of valid data bytes. The block decides which handshake to return for each control data packet. It also drives the byte writes into the endpoint's receive buffer and keeps the endpoint's state registers.

A SETUP transaction is always taken in, even if firmware has not yet dealt with the previous one. When the transaction completes with exactly eight data bytes, the block does the following:

- returns an ACK;
- removes any halt on both directions;
- disarms the transmit side;
- zeroes both byte counts;
- forces both data toggles to 1;
- raises a setup interrupt flag.

While that flag is up, every OUT data packet on the endpoint is refused with a NAK, and its bytes are not written. This keeps the setup bytes in the buffer intact until firmware has read them and cleared the flag.

Firmware can also halt either direction, arm the transmit side with a byte count, and release the receive buffer. The packet engine reports completed IN transfers through `in_acked`, which disarms the transmit side and flips its toggle.

Top module: `ep0_setup_ctl`

## Requirements
- R1: After reset, the following are all 0: `setup_irq`, both stall bits, both toggles, `tx_armed`, both byte counts, `hs_vld` and `buf_we`.
- R2: Every data byte of a SETUP transaction is written to buffer address equal to its index within the packet (0, 1, 2, ...), whatever the state of `setup_irq` or the stall bits.
- R3: A SETUP data packet of exactly 8 bytes gives `hs_vld`=1 with `hs_code`=0 (ACK) for one cycle, in the cycle after `rx_pkt_end`. This holds even when `setup_irq` is already 1.
- R4: A SETUP data packet whose length is not 8 gives no handshake (`hs_vld` stays 0) and changes no state register.
- R5: An accepted SETUP clears `stall_rx`, `stall_tx`, `tx_armed`, `tx_cnt` and `rx_cnt`. All of these take effect in the cycle after `rx_pkt_end`.
- R6: An accepted SETUP sets `rx_tog` and `tx_tog` to 1.
- R7: An accepted SETUP sets `setup_irq`. The flag falls only in the cycle after a `fw_setup_clr` pulse. If an accepted SETUP ends in the same cycle as the clear, the flag stays 1.
- R8: While `setup_irq` is 1, an OUT data packet gets `hs_code`=1 (NAK). None of its bytes are written, and `rx_cnt` and `rx_tog` stay unchanged.
- R9: With `setup_irq` at 0 and `stall_rx` at 1, an OUT data packet gets `hs_code`=2 (STALL), writes no byte and changes no count or toggle. `fw_stall_rx_set` and `fw_stall_tx_set` set the stall bits.
- R10: An OUT data packet with neither condition gets an ACK. Its byte i is written to address `rx_cnt`+i. Writes at addresses of DEPTH or above are dropped. `rx_cnt` grows by the packet length, limited to DEPTH, and `rx_tog` flips.
- R11: `fw_rx_clr` zeroes `rx_cnt` on the next edge. If an accepted OUT packet ends in the same cycle, the pulse is ignored.
- R12: `fw_tx_arm` loads `tx_cnt` from `fw_tx_len` and sets `tx_armed`. `in_acked` while armed clears `tx_armed` and flips `tx_tog`, and has no effect when the transmit side is not armed. An accepted SETUP overrides all firmware controls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup | input | 1 | SETUP token to the control endpoint (pulse) |
| tok_out | input | 1 | OUT token to the control endpoint (pulse) |
| rx_byte_vld | input | 1 | Data byte valid in this cycle |
| rx_byte | input | 8 | Data byte |
| rx_pkt_end | input | 1 | Data packet completed, CRC good (pulse) |
| in_acked | input | 1 | Host acknowledged an IN packet (pulse) |
| fw_setup_clr | input | 1 | Firmware clear of the setup flag |
| fw_rx_clr | input | 1 | Firmware release of the receive buffer |
| fw_tx_arm | input | 1 | Firmware arms the transmit side |
| fw_tx_len | input | CNT_W | Transmit byte count loaded on arm |
| fw_stall_rx_set | input | 1 | Firmware halts the receive direction |
| fw_stall_tx_set | input | 1 | Firmware halts the transmit direction |
| hs_vld | output | 1 | Handshake request valid (one cycle) |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| buf_we | output | 1 | Receive buffer write enable |
| buf_addr | output | ADDR_W | Receive buffer write address |
| buf_wdata | output | 8 | Receive buffer write data |
| rx_cnt | output | CNT_W | Receive byte count |
| tx_cnt | output | CNT_W | Transmit byte count |
| tx_armed | output | 1 | Transmit side armed |
| rx_tog | output | 1 | Receive data toggle |
| tx_tog | output | 1 | Transmit data toggle |
| stall_rx | output | 1 | Receive direction halted |
| stall_tx | output | 1 | Transmit direction halted |
| setup_irq | output | 1 | Setup received, awaiting firmware |

## Verification
The bench sends a second SETUP while the flag is still pending. A design that gated the setup ACK on the flag would go silent at that point. Setup packets of five and nine bytes must leave every register untouched, so a design that skipped the length check would raise the flag. The bench ends a SETUP in the same cycle as a firmware clear; a design with the wrong priority would lose the flag. It also ends an OUT packet in the same cycle as a buffer release, which catches an `rx_cnt` that wrongly returns to zero. Finally, an OUT burst longer than the buffer exposes writes that wrap around or a count that runs past DEPTH.

// File: rtl/ep0_setup_pkg.sv
package ep0_setup_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_code_e;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_SETUP = 2'd1,
        PK_OUT   = 2'd2
    } pkt_kind_e;

endpackage

// File: rtl/ep0_pkt_track.sv
// Tracks which token opened the current data packet and the byte index in it.
module ep0_pkt_track
    import ep0_setup_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_setup,
    input  logic             tok_out,
    input  logic             byte_vld,
    input  logic             pkt_end,
    output pkt_kind_e        kind,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] end_len
);

    typedef struct packed {
        pkt_kind_e        kind;
        logic [LEN_W-1:0] len;
    } trk_s;

    trk_s trk_d, trk_q;
    logic at_max;

    always_comb begin
        at_max = (trk_q.len == {LEN_W{1'b1}});
        trk_d  = trk_q;
        if (tok_setup) begin
            trk_d.kind = PK_SETUP;
            trk_d.len  = '0;
        end else if (tok_out) begin
            trk_d.kind = PK_OUT;
            trk_d.len  = '0;
        end else if (pkt_end) begin
            trk_d.kind = PK_IDLE;
            trk_d.len  = '0;
        end else if (byte_vld && !at_max) begin
            trk_d.len = trk_q.len + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{kind: PK_IDLE, len: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign kind    = trk_q.kind;
    assign idx     = trk_q.len;
    assign end_len = (byte_vld && !at_max) ? trk_q.len + 1'b1 : trk_q.len;

    // R2: byte index restarts at zero after every token
    a_r2_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_setup || tok_out) |=> (idx == '0));

endmodule

// File: rtl/ep0_ctl_regs.sv
// Control endpoint state: setup flag, stalls, toggles, counts and handshake.
module ep0_ctl_regs
    import ep0_setup_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pkt_kind_e        kind,
    input  logic             pkt_end,
    input  logic [CNT_W-1:0] end_len,
    input  logic             in_acked,
    input  logic             fw_setup_clr,
    input  logic             fw_rx_clr,
    input  logic             fw_tx_arm,
    input  logic [CNT_W-1:0] fw_tx_len,
    input  logic             fw_stall_rx_set,
    input  logic             fw_stall_tx_set,
    output logic             hs_vld,
    output hs_code_e         hs_code,
    output logic [CNT_W-1:0] rx_cnt,
    output logic [CNT_W-1:0] tx_cnt,
    output logic             tx_armed,
    output logic             rx_tog,
    output logic             tx_tog,
    output logic             stall_rx,
    output logic             stall_tx,
    output logic             setup_irq
);

    localparam logic [CNT_W:0]   DEPTH_X   = (CNT_W+1)'(DEPTH);
    localparam logic [CNT_W-1:0] SETUP_LEN = CNT_W'(8);

    typedef struct packed {
        logic             hs_vld;
        hs_code_e         hs_code;
        logic [CNT_W-1:0] rx_cnt;
        logic [CNT_W-1:0] tx_cnt;
        logic             tx_armed;
        logic             rx_tog;
        logic             tx_tog;
        logic             stall_rx;
        logic             stall_tx;
        logic             setup_irq;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic setup_ok;
    logic setup_bad;
    logic out_end;
    logic [CNT_W:0] rx_sum;

    always_comb begin
        setup_ok  = pkt_end && (kind == PK_SETUP) && (end_len == SETUP_LEN);
        setup_bad = pkt_end && (kind == PK_SETUP) && (end_len != SETUP_LEN);
        out_end   = pkt_end && (kind == PK_OUT);
        rx_sum    = {1'b0, ctl_q.rx_cnt} + {1'b0, end_len};

        ctl_d         = ctl_q;
        ctl_d.hs_vld  = 1'b0;
        ctl_d.hs_code = HS_ACK;

        // firmware controls, lowest priority
        if (fw_stall_rx_set) ctl_d.stall_rx  = 1'b1;
        if (fw_stall_tx_set) ctl_d.stall_tx  = 1'b1;
        if (fw_setup_clr)    ctl_d.setup_irq = 1'b0;
        if (fw_rx_clr)       ctl_d.rx_cnt    = '0;
        if (in_acked && ctl_q.tx_armed) begin
            ctl_d.tx_armed = 1'b0;
            ctl_d.tx_tog   = ~ctl_q.tx_tog;
        end
        if (fw_tx_arm) begin
            ctl_d.tx_armed = 1'b1;
            ctl_d.tx_cnt   = fw_tx_len;
        end

        // OUT data completion
        if (out_end) begin
            ctl_d.hs_vld = 1'b1;
            if (ctl_q.setup_irq) begin
                ctl_d.hs_code = HS_NAK;
            end else if (ctl_q.stall_rx) begin
                ctl_d.hs_code = HS_STALL;
            end else begin
                ctl_d.hs_code = HS_ACK;
                ctl_d.rx_cnt  = (rx_sum > DEPTH_X) ? DEPTH_X[CNT_W-1:0] : rx_sum[CNT_W-1:0];
                ctl_d.rx_tog  = ~ctl_q.rx_tog;
            end
        end

        // accepted SETUP overrides everything
        if (setup_ok) begin
            ctl_d.hs_vld    = 1'b1;
            ctl_d.hs_code   = HS_ACK;
            ctl_d.setup_irq = 1'b1;
            ctl_d.stall_rx  = 1'b0;
            ctl_d.stall_tx  = 1'b0;
            ctl_d.tx_armed  = 1'b0;
            ctl_d.tx_cnt    = '0;
            ctl_d.rx_cnt    = '0;
            ctl_d.rx_tog    = 1'b1;
            ctl_d.tx_tog    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{hs_vld: 1'b0, hs_code: HS_ACK, rx_cnt: '0, tx_cnt: '0,
                       tx_armed: 1'b0, rx_tog: 1'b0, tx_tog: 1'b0,
                       stall_rx: 1'b0, stall_tx: 1'b0, setup_irq: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hs_vld    = ctl_q.hs_vld;
    assign hs_code   = ctl_q.hs_code;
    assign rx_cnt    = ctl_q.rx_cnt;
    assign tx_cnt    = ctl_q.tx_cnt;
    assign tx_armed  = ctl_q.tx_armed;
    assign rx_tog    = ctl_q.rx_tog;
    assign tx_tog    = ctl_q.tx_tog;
    assign stall_rx  = ctl_q.stall_rx;
    assign stall_tx  = ctl_q.stall_tx;
    assign setup_irq = ctl_q.setup_irq;

    a_r3_setup_acked: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ok |=> (hs_vld && hs_code == HS_ACK));

    a_r4_bad_setup_silent: assert property (@(posedge clk) disable iff (!rst_n)
        setup_bad |=> !hs_vld);

    a_r5_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ok |=> (!stall_rx && !stall_tx && !tx_armed && rx_cnt == '0 && tx_cnt == '0));

    a_r6_toggles_one: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ok |=> (rx_tog && tx_tog));

    a_r7_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_irq && !fw_setup_clr) |=> setup_irq);

    a_r8_nak_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_end && setup_irq) |=> (hs_vld && hs_code == HS_NAK && $stable(rx_cnt) && $stable(rx_tog)));

    a_r10_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rx_cnt} <= DEPTH_X));

endmodule

// File: rtl/ep0_setup_ctl.sv
// Control endpoint SETUP handler top.
module ep0_setup_ctl
    import ep0_setup_pkg::*;
#(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_setup,
    input  logic              tok_out,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_pkt_end,
    input  logic              in_acked,
    input  logic              fw_setup_clr,
    input  logic              fw_rx_clr,
    input  logic              fw_tx_arm,
    input  logic [CNT_W-1:0]  fw_tx_len,
    input  logic              fw_stall_rx_set,
    input  logic              fw_stall_tx_set,
    output logic              hs_vld,
    output logic [1:0]        hs_code,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic              tx_armed,
    output logic              rx_tog,
    output logic              tx_tog,
    output logic              stall_rx,
    output logic              stall_tx,
    output logic              setup_irq
);

    localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

    pkt_kind_e        kind;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] end_len;
    hs_code_e         hs_code_e_w;
    logic [CNT_W:0]   wr_pos;
    logic             wr_ok;

    ep0_pkt_track #(.LEN_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_setup(tok_setup),
        .tok_out  (tok_out),
        .byte_vld (rx_byte_vld),
        .pkt_end  (rx_pkt_end),
        .kind     (kind),
        .idx      (idx),
        .end_len  (end_len)
    );

    ep0_ctl_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .kind           (kind),
        .pkt_end        (rx_pkt_end),
        .end_len        (end_len),
        .in_acked       (in_acked),
        .fw_setup_clr   (fw_setup_clr),
        .fw_rx_clr      (fw_rx_clr),
        .fw_tx_arm      (fw_tx_arm),
        .fw_tx_len      (fw_tx_len),
        .fw_stall_rx_set(fw_stall_rx_set),
        .fw_stall_tx_set(fw_stall_tx_set),
        .hs_vld         (hs_vld),
        .hs_code        (hs_code_e_w),
        .rx_cnt         (rx_cnt),
        .tx_cnt         (tx_cnt),
        .tx_armed       (tx_armed),
        .rx_tog         (rx_tog),
        .tx_tog         (tx_tog),
        .stall_rx       (stall_rx),
        .stall_tx       (stall_tx),
        .setup_irq      (setup_irq)
    );

    assign hs_code = hs_code_e_w;

    // Buffer write path: setup bytes always land from address zero,
    // OUT bytes only when neither pending setup nor receive halt blocks them.
    always_comb begin
        wr_pos = '0;
        wr_ok  = 1'b0;
        if (kind == PK_SETUP) begin
            wr_pos = {1'b0, idx};
            wr_ok  = 1'b1;
        end else if (kind == PK_OUT) begin
            wr_pos = {1'b0, rx_cnt} + {1'b0, idx};
            wr_ok  = !setup_irq && !stall_rx;
        end
    end

    assign buf_we    = rx_byte_vld && wr_ok && (wr_pos < DEPTH_X);
    assign buf_addr  = wr_pos[ADDR_W-1:0];
    assign buf_wdata = rx_byte;

    // R8: no buffer write for OUT data while the setup flag is pending
    a_r8_no_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PK_OUT && setup_irq) |-> !buf_we);

    // R9: no buffer write for OUT data while the receive side is halted
    a_r9_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PK_OUT && stall_rx) |-> !buf_we);

    // R2: setup bytes are never blocked
    a_r2_setup_write: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PK_SETUP && rx_byte_vld && {1'b0, idx} < DEPTH_X) |-> buf_we);

endmodule

// File: tb/ep0_setup_ctl_tb.sv
module ep0_setup_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int ADDR_W     = 6;
    localparam int CNT_W      = 7;
    localparam int MAX_CYC    = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_setup = 0, tok_out = 0, rx_byte_vld = 0, rx_pkt_end = 0, in_acked = 0;
    logic [7:0] rx_byte = '0;
    logic fw_setup_clr = 0, fw_rx_clr = 0, fw_tx_arm = 0, fw_stall_rx_set = 0, fw_stall_tx_set = 0;
    logic [CNT_W-1:0] fw_tx_len = '0;

    logic hs_vld, buf_we, tx_armed, rx_tog, tx_tog, stall_rx, stall_tx, setup_irq;
    logic [1:0] hs_code;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0] buf_wdata;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;

    ep0_setup_ctl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_out(tok_out),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_pkt_end(rx_pkt_end),
        .in_acked(in_acked), .fw_setup_clr(fw_setup_clr), .fw_rx_clr(fw_rx_clr),
        .fw_tx_arm(fw_tx_arm), .fw_tx_len(fw_tx_len), .fw_stall_rx_set(fw_stall_rx_set),
        .fw_stall_tx_set(fw_stall_tx_set), .hs_vld(hs_vld), .hs_code(hs_code),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rx_cnt(rx_cnt),
        .tx_cnt(tx_cnt), .tx_armed(tx_armed), .rx_tog(rx_tog), .tx_tog(tx_tog),
        .stall_rx(stall_rx), .stall_tx(stall_tx), .setup_irq(setup_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit started  = 0;
    bit done     = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 setup data, 2 out data
    int m_kind = 0, m_len = 0;
    int m_flag = 0, m_srx = 0, m_stx = 0, m_trx = 0, m_ttx = 0, m_arm = 0;
    int m_txc = 0, m_rxc = 0, m_hsv = 0, m_hsc = 0;

    always @(posedge clk) begin
        int elen;
        int n_flag, n_srx, n_stx, n_trx, n_ttx, n_arm, n_txc, n_rxc, n_hsv, n_hsc;
        cycles++;
        if (!rst_n) begin
            m_kind = 0; m_len = 0; m_flag = 0; m_srx = 0; m_stx = 0; m_trx = 0; m_ttx = 0;
            m_arm = 0; m_txc = 0; m_rxc = 0; m_hsv = 0; m_hsc = 0;
        end else begin
            elen = m_len + ((rx_byte_vld && m_len < 127) ? 1 : 0);
            n_flag = m_flag; n_srx = m_srx; n_stx = m_stx; n_trx = m_trx; n_ttx = m_ttx;
            n_arm = m_arm; n_txc = m_txc; n_rxc = m_rxc; n_hsv = 0; n_hsc = 0;
            if (fw_stall_rx_set) n_srx = 1;
            if (fw_stall_tx_set) n_stx = 1;
            if (fw_setup_clr) n_flag = 0;
            if (fw_rx_clr) n_rxc = 0;
            if (in_acked && m_arm) begin n_arm = 0; n_ttx = 1 - m_ttx; end
            if (fw_tx_arm) begin n_arm = 1; n_txc = fw_tx_len; end
            if (rx_pkt_end && m_kind == 2) begin
                n_hsv = 1;
                if (m_flag) n_hsc = 1;
                else if (m_srx) n_hsc = 2;
                else begin
                    n_hsc = 0;
                    n_rxc = (m_rxc + elen > DEPTH) ? DEPTH : m_rxc + elen;
                    n_trx = 1 - m_trx;
                end
            end
            if (rx_pkt_end && m_kind == 1 && elen == 8) begin
                n_hsv = 1; n_hsc = 0; n_flag = 1; n_srx = 0; n_stx = 0; n_arm = 0;
                n_txc = 0; n_rxc = 0; n_trx = 1; n_ttx = 1;
            end
            m_flag = n_flag; m_srx = n_srx; m_stx = n_stx; m_trx = n_trx; m_ttx = n_ttx;
            m_arm = n_arm; m_txc = n_txc; m_rxc = n_rxc; m_hsv = n_hsv; m_hsc = n_hsc;
            if (tok_setup) begin m_kind = 1; m_len = 0; end
            else if (tok_out) begin m_kind = 2; m_len = 0; end
            else if (rx_pkt_end) begin m_kind = 0; m_len = 0; end
            else if (rx_byte_vld && m_len < 127) m_len++;
        end
        started = 1;
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int e_we, e_addr;
        if (started && !done) begin
            e_addr = (m_kind == 1) ? m_len : m_rxc + m_len;
            e_we = (rx_byte_vld && rst_n &&
                    (m_kind == 1 || (m_kind == 2 && !m_flag && !m_srx)) && e_addr < DEPTH) ? 1 : 0;
            chk("hs_vld", hs_vld, m_hsv);
            if (m_hsv) chk("hs_code", hs_code, m_hsc);
            chk("buf_we", buf_we, e_we);
            if (e_we) begin
                chk("buf_addr", buf_addr, e_addr);
                chk("buf_wdata", buf_wdata, rx_byte);
            end
            chk("rx_cnt", rx_cnt, m_rxc);
            chk("tx_cnt", tx_cnt, m_txc);
            chk("tx_armed", tx_armed, m_arm);
            chk("rx_tog", rx_tog, m_trx);
            chk("tx_tog", tx_tog, m_ttx);
            chk("stall_rx", stall_rx, m_srx);
            chk("stall_tx", stall_tx, m_stx);
            chk("setup_irq", setup_irq, m_flag);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(bit is_setup, int n, bit clr_at_end, bit rxclr_at_end);
        if (is_setup) tok_setup = 1; else tok_out = 1;
        step();
        tok_setup = 0; tok_out = 0;
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1;
            rx_byte = is_setup ? 8'(8'hA0 + i) : 8'(8'h30 + i);
            step();
        end
        rx_byte_vld = 0; rx_byte = '0;
        rx_pkt_end = 1; fw_setup_clr = clr_at_end; fw_rx_clr = rxclr_at_end;
        step();
        rx_pkt_end = 0; fw_setup_clr = 0; fw_rx_clr = 0;
        step();
        step();
    endtask

    task automatic pulse_clr();
        fw_setup_clr = 1; step(); fw_setup_clr = 0; step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #1;
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1;
        step(); step();

        cur_req = "R12";
        fw_stall_rx_set = 1; fw_stall_tx_set = 1; fw_tx_arm = 1; fw_tx_len = 7'd5;
        step();
        fw_stall_rx_set = 0; fw_stall_tx_set = 0; fw_tx_arm = 0;
        in_acked = 1; step(); in_acked = 0;
        in_acked = 1; step(); in_acked = 0;   // not armed: no effect
        fw_tx_arm = 1; fw_tx_len = 7'd9; step(); fw_tx_arm = 0; step();

        cur_req = "R5";  // also R2, R3, R6: accepted setup resets stalls, counts, toggles
        send_pkt(1, 8, 0, 0);

        cur_req = "R8";
        send_pkt(0, 4, 0, 0);

        cur_req = "R3";  // second setup while flag pending still ACKed
        send_pkt(1, 8, 0, 0);

        cur_req = "R7";
        fw_stall_rx_set = 1; step(); fw_stall_rx_set = 0;
        pulse_clr();

        cur_req = "R9";
        send_pkt(0, 2, 0, 0);

        cur_req = "R6";
        send_pkt(1, 8, 0, 0);
        pulse_clr();

        cur_req = "R10";
        send_pkt(0, 4, 0, 0);
        send_pkt(0, 3, 0, 0);

        cur_req = "R11";
        send_pkt(0, 2, 0, 1);      // release ignored at accepted OUT end
        fw_rx_clr = 1; step(); fw_rx_clr = 0; step();

        cur_req = "R10";
        send_pkt(0, 70, 0, 0);     // overflow: writes stop, count saturates
        send_pkt(0, 3, 0, 0);

        cur_req = "R4";
        fw_stall_tx_set = 1; fw_tx_arm = 1; fw_tx_len = 7'd3; step();
        fw_stall_tx_set = 0; fw_tx_arm = 0;
        send_pkt(1, 5, 0, 0);
        send_pkt(1, 9, 0, 0);

        cur_req = "R7";  // setup ending together with firmware clear keeps the flag
        send_pkt(1, 8, 1, 0);
        send_pkt(0, 1, 0, 0);
        pulse_clr();

        cur_req = "R2";
        send_pkt(1, 8, 0, 0);

        step(); step();
        finish_run();
    end

    initial begin
        wait (cycles >= MAX_CYC);
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYC);
        finish_run();
    end

endmodule